// File: doc/BRIEF.md
# Fractional-Period Adjustable Real-Time Clock

This block is the time-of-day counter of a precision time protocol node. On every rising edge of the reference clock it adds a programmable period to a time value that is held as whole seconds, nanoseconds and a visible sub-nanosecond fraction. The period word has eight integer nanosecond bits and thirty-two fractional nanosecond bits. Only the top eight fractional bits are visible, so the lower twenty-four bits are kept in a hidden residue register. Their carries flow into the visible fraction and from there into the nanosecond count, and the average rate stays exact to 2^-32 ns per cycle.

Software can replace the base period at any time. It can also start a temporary frequency correction: it writes an adjustment period and a cycle count, and the adjustment period then overrides the base period for exactly that many edges. A synchronous time-set path loads seconds and nanoseconds directly. That path is used for coarse phase steps.

Top module: `frac_rtc`

## Requirements
- R1: While rstN is low, secOut, nsOut and subNsOut are zero, no adjustment is pending, and the base period is NOMINAL_NS whole nanoseconds. After release, each edge advances nsOut by 8 with the defaults.
- R2: On every edge without a time-set, the time advances by the selected period: the adjustment period while an adjustment is pending, and the base period otherwise.
- R3: A period word carries integer nanoseconds in bits [39:32] and the fraction in units of 2^-32 ns in bits [31:0]. A base period written with periodWr is stored at that edge and used from the following edge onward.
- R4: subNsOut shows fraction bits [31:24] of the accumulated time. The lower 24 bits build up in a hidden residue. A carry out of the fraction adds one nanosecond.
- R5: When the nanosecond sum reaches or exceeds 1,000,000,000, 10^9 is subtracted and secOut increments on the same edge.
- R6: adjWr stores adjPeriodIn and adjCountIn at that edge. The next adjCountIn edges use the adjustment period, and later edges use the base period again.
- R7: An adjustment written with a count of zero has no effect on the advance.
- R8: setWr loads secOut and nsOut from setSec and setNs at that edge and clears subNsOut and the residue. It takes priority over accumulation and rollover. setNs must be below 10^9.
- R9: A pending adjustment keeps counting down on an edge taken by a time-set, so that edge consumes one adjustment cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodWr | input | 1 | Store periodIn as the base period |
| periodIn | input | 40 | Base period, 8.32 fixed-point nanoseconds |
| adjWr | input | 1 | Start an adjustment |
| adjPeriodIn | input | 40 | Adjustment period, 8.32 fixed-point nanoseconds |
| adjCountIn | input | 32 | Number of edges the adjustment lasts |
| setWr | input | 1 | Load time from setSec and setNs |
| setSec | input | 48 | Seconds value to load |
| setNs | input | 32 | Nanoseconds value to load |
| secOut | output | 48 | Current seconds |
| nsOut | output | 32 | Current nanoseconds |
| subNsOut | output | 8 | Current fraction of a nanosecond, units of 2^-8 ns |

## Verification
Two events can fall on the same edge: a time-set and the advance that would otherwise happen, including a pending rollover. The bench loads a time a few nanoseconds below a second boundary and then issues a second time-set on the very next edge. After that edge the loaded value must appear exactly, with no second carried.

The other collision is a time-set that arrives during a running adjustment. The bench starts a four-cycle correction and sets the time on the next edge. The final nanosecond count must show that the set edge used up one adjustment cycle: three 10 ns steps are followed by a return to 8 ns.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W    = 48;
  localparam int NS_W     = 32;
  localparam int SUBNS_W  = 8;
  localparam int INT_W    = 8;
  localparam int FRAC_W   = 32;
  localparam int PERIOD_W = INT_W + FRAC_W;
  localparam int RES_W    = FRAC_W - SUBNS_W;
  localparam longint unsigned NS_PER_SEC = 64'd1000000000;

  typedef struct packed {
    logic                loadTime;
    logic [PERIOD_W-1:0] step;
  } rtc_step_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int NOMINAL_NS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                periodWr,
  input  logic [PERIOD_W-1:0] periodIn,
  input  logic                adjWr,
  input  logic [PERIOD_W-1:0] adjPeriodIn,
  input  logic [CNT_W-1:0]    adjCountIn,
  input  logic                setWr,
  output rtc_step_t           stepOut
);
  localparam logic [PERIOD_W-1:0] NOMINAL_PERIOD =
    {INT_W'(NOMINAL_NS), {FRAC_W{1'b0}}};

  logic [PERIOD_W-1:0] basePeriod;
  logic [PERIOD_W-1:0] adjPeriod;
  logic [CNT_W-1:0]    adjLeft;
  logic                adjActive;

  assign adjActive = (adjLeft != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      basePeriod <= NOMINAL_PERIOD;
      adjPeriod  <= '0;
      adjLeft    <= '0;
    end else begin
      if (periodWr) basePeriod <= periodIn;
      if (adjWr) begin
        adjPeriod <= adjPeriodIn;
        adjLeft   <= adjCountIn;
      end else if (adjActive) begin
        adjLeft <= adjLeft - 1'b1;
      end
    end
  end

  always_comb begin
    stepOut.loadTime = setWr;
    stepOut.step     = adjActive ? adjPeriod : basePeriod;
  end

  // R6, R9: a pending adjustment counts down on every edge, including set edges
  assert_adj_countdown_R6: assert property (@(posedge clk) disable iff (!rstN)
    (adjActive && !adjWr) |=> adjLeft == $past(adjLeft) - 1'b1);

  // R3: a written base period is held from the next edge
  assert_period_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    periodWr |=> basePeriod == $past(periodIn));
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rtc_step_t         stepIn,
  input  logic [SEC_W-1:0]  setSec,
  input  logic [NS_W-1:0]   setNs,
  output logic [SEC_W-1:0]  secQ,
  output logic [NS_W-1:0]   nsQ,
  output logic [SUBNS_W-1:0] subQ
);
  localparam logic [NS_W:0]   NS_WRAP  = (NS_W+1)'(NS_PER_SEC);
  localparam logic [NS_W-1:0] NS_LIMIT = NS_W'(NS_PER_SEC);

  logic [RES_W-1:0] resQ;
  logic [FRAC_W:0]  fracSum;
  logic [NS_W:0]    nsSum;
  logic [NS_W:0]    nsNext;
  logic             secCarry;

  always_comb begin
    fracSum  = {1'b0, subQ, resQ} + {1'b0, stepIn.step[FRAC_W-1:0]};
    nsSum    = {1'b0, nsQ}
             + (NS_W+1)'(stepIn.step[PERIOD_W-1:FRAC_W])
             + (NS_W+1)'(fracSum[FRAC_W]);
    secCarry = (nsSum >= NS_WRAP);
    nsNext   = secCarry ? (nsSum - NS_WRAP) : nsSum;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ <= '0;
      nsQ  <= '0;
      subQ <= '0;
      resQ <= '0;
    end else if (stepIn.loadTime) begin
      secQ <= setSec;
      nsQ  <= setNs;
      subQ <= '0;
      resQ <= '0;
    end else begin
      secQ <= secQ + SEC_W'(secCarry);
      nsQ  <= nsNext[NS_W-1:0];
      subQ <= fracSum[FRAC_W-1:RES_W];
      resQ <= fracSum[RES_W-1:0];
    end
  end

  // R5: nanoseconds stay below one second once in range
  assert_ns_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!stepIn.loadTime && nsQ < NS_LIMIT) |=> nsQ < NS_LIMIT);

  // R5: seconds advance by at most one per edge
  assert_sec_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    !stepIn.loadTime |=> (secQ == $past(secQ)) || (secQ == $past(secQ) + 1'b1));

  // R8: time-set wins and clears the fraction
  assert_set_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    stepIn.loadTime |=> (secQ == $past(setSec)) && (nsQ == $past(setNs))
                        && (subQ == '0) && (resQ == '0));
endmodule

// File: rtl/frac_rtc.sv
module frac_rtc
  import rtc_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int NOMINAL_NS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                periodWr,
  input  logic [39:0]         periodIn,
  input  logic                adjWr,
  input  logic [39:0]         adjPeriodIn,
  input  logic [CNT_W-1:0]    adjCountIn,
  input  logic                setWr,
  input  logic [47:0]         setSec,
  input  logic [31:0]         setNs,
  output logic [47:0]         secOut,
  output logic [31:0]         nsOut,
  output logic [7:0]          subNsOut
);
  rtc_step_t stepBus;

  rtc_ctrl #(.CNT_W(CNT_W), .NOMINAL_NS(NOMINAL_NS)) ctrl (
    .clk(clk), .rstN(rstN),
    .periodWr(periodWr), .periodIn(periodIn),
    .adjWr(adjWr), .adjPeriodIn(adjPeriodIn), .adjCountIn(adjCountIn),
    .setWr(setWr), .stepOut(stepBus)
  );

  rtc_datapath datapath (
    .clk(clk), .rstN(rstN), .stepIn(stepBus),
    .setSec(setSec), .setNs(setNs),
    .secQ(secOut), .nsQ(nsOut), .subQ(subNsOut)
  );
endmodule

// File: tb/frac_rtc_test.sv
`timescale 1ns/1ps
module frac_rtc_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        periodWr = 1'b0;
  logic [39:0] periodIn = '0;
  logic        adjWr = 1'b0;
  logic [39:0] adjPeriodIn = '0;
  logic [31:0] adjCountIn = '0;
  logic        setWr = 1'b0;
  logic [47:0] setSec = '0;
  logic [31:0] setNs = '0;
  logic [47:0] secOut;
  logic [31:0] nsOut;
  logic [7:0]  subNsOut;

  int runCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  localparam logic [39:0] P8    = 40'h08_0000_0000;
  localparam logic [39:0] P7_5  = 40'h07_8000_0000;
  localparam logic [39:0] P8_H  = 40'h08_0080_0000;
  localparam logic [39:0] P10   = 40'h0A_0000_0000;
  localparam logic [39:0] P20   = 40'h14_0000_0000;

  always #4 clk = ~clk;

  frac_rtc uut (
    .clk(clk), .rstN(rstN),
    .periodWr(periodWr), .periodIn(periodIn),
    .adjWr(adjWr), .adjPeriodIn(adjPeriodIn), .adjCountIn(adjCountIn),
    .setWr(setWr), .setSec(setSec), .setNs(setNs),
    .secOut(secOut), .nsOut(nsOut), .subNsOut(subNsOut)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic steps(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadPeriod(input logic [39:0] p);
    periodWr = 1'b1; periodIn = p;
    @(negedge clk);
    periodWr = 1'b0;
  endtask

  task automatic loadTime(input logic [47:0] s, input logic [31:0] ns);
    setWr = 1'b1; setSec = s; setNs = ns;
    @(negedge clk);
    setWr = 1'b0;
  endtask

  task automatic testReset();
    steps(3);
    check("R1 sec in reset", 64'(secOut), 0);
    check("R1 ns in reset", 64'(nsOut), 0);
    check("R1 subns in reset", 64'(subNsOut), 0);
    rstN = 1'b1;
    steps(5);
    check("R1 nominal 8ns after reset", 64'(nsOut), 40);
    check("R2 subns stays zero", 64'(subNsOut), 0);
  endtask

  task automatic testSet();
    loadTime(48'h1234_5678_9ABC, 32'd500);
    check("R8 sec loaded", 64'(secOut), 64'h1234_5678_9ABC);
    check("R8 ns loaded", 64'(nsOut), 500);
    steps(3);
    check("R2 advance after set", 64'(nsOut), 524);
  endtask

  task automatic testFraction();
    loadPeriod(P8_H);
    loadTime(48'd2, 32'd0);
    steps(1);
    check("R4 half-lsb hidden ns", 64'(nsOut), 8);
    check("R4 half-lsb hidden sub", 64'(subNsOut), 0);
    steps(1);
    check("R4 residue carry into sub", 64'(subNsOut), 1);
    check("R4 ns after two", 64'(nsOut), 16);
    steps(1);
    loadTime(48'd3, 32'd0);
    steps(1);
    check("R8 residue cleared by set", 64'(subNsOut), 0);
    check("R8 ns after set", 64'(nsOut), 8);
    loadPeriod(P7_5);
    loadTime(48'd4, 32'd0);
    steps(1);
    check("R3 integer part", 64'(nsOut), 7);
    check("R3 fraction part", 64'(subNsOut), 8'h80);
    steps(1);
    check("R4 fraction carry into ns", 64'(nsOut), 15);
    check("R4 fraction wraps", 64'(subNsOut), 0);
  endtask

  task automatic testRollover();
    loadPeriod(P8);
    loadTime(48'd7, 32'd999_999_992);
    steps(1);
    check("R5 exact boundary sec", 64'(secOut), 8);
    check("R5 exact boundary ns", 64'(nsOut), 0);
    loadTime(48'd7, 32'd999_999_995);
    steps(1);
    check("R5 overshoot sec", 64'(secOut), 8);
    check("R5 overshoot ns", 64'(nsOut), 3);
    loadPeriod(P7_5);
    loadTime(48'd9, 32'd999_999_992);
    steps(1);
    check("R5 below boundary ns", 64'(nsOut), 999_999_999);
    steps(1);
    check("R5 carry-driven rollover sec", 64'(secOut), 10);
    check("R5 carry-driven rollover ns", 64'(nsOut), 7);
    loadPeriod(P8);
  endtask

  task automatic testAdjust();
    setWr = 1'b1; setSec = 48'd0; setNs = 32'd0;
    adjWr = 1'b1; adjPeriodIn = P10; adjCountIn = 32'd3;
    @(negedge clk);
    setWr = 1'b0; adjWr = 1'b0;
    steps(3);
    check("R6 three adjusted steps", 64'(nsOut), 30);
    steps(2);
    check("R6 back to base period", 64'(nsOut), 46);
  endtask

  task automatic testAdjustZero();
    setWr = 1'b1; setSec = 48'd0; setNs = 32'd0;
    adjWr = 1'b1; adjPeriodIn = P20; adjCountIn = 32'd0;
    @(negedge clk);
    setWr = 1'b0; adjWr = 1'b0;
    steps(4);
    check("R7 zero count ignored", 64'(nsOut), 32);
  endtask

  task automatic testCollide();
    adjWr = 1'b1; adjPeriodIn = P10; adjCountIn = 32'd4;
    @(negedge clk);
    adjWr = 1'b0;
    loadTime(48'd1, 32'd100);
    steps(4);
    check("R9 set edge consumes adjust cycle", 64'(nsOut), 138);
    check("R9 sec unchanged", 64'(secOut), 1);
    loadTime(48'd5, 32'd999_999_996);
    loadTime(48'd6, 32'd5);
    check("R8 set beats rollover sec", 64'(secOut), 6);
    check("R8 set beats rollover ns", 64'(nsOut), 5);
    steps(1);
    check("R2 advance after collision", 64'(nsOut), 13);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testSet();
    testFraction();
    testRollover();
    testAdjust();
    testAdjustZero();
    testCollide();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      runCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runCount, failCount);
      $finish;
    end
  end
endmodule